// File: doc/BRIEF.md
# Third-Order Decimating Filter with Chopping

This block turns a single-bit oversampled stream from a sigma-delta modulator into wide signed results. The stream arrives at a sixteenth of the master clock, marked by a valid strobe. The filter is a sinc-cubed low-pass decimator built from three integrators and three combs. A 12-bit rate word sets the decimation ratio. The first notch sits at the output rate, and further notches repeat at multiples of it. Changing the word moves the notches but leaves the shape of the response unchanged.

In nonchop mode one result comes out for every rate-word samples. In chop mode the block drives a polarity line for the analog front end and toggles it after each result. It throws away the two decimation periods during which the filter still holds samples from the old polarity, and it negates each result taken under the inverted polarity. So in chop mode one result comes out every three periods. Successive chop results come from opposite polarities and belong together in pairs.

Top module: `sinc3_chop_decim`

## Requirements
- R1: While reset is asserted, and until the first result, `dout_valid` is 0, `dout` is 0 and `chop_pol` is 0.
- R2: Input bit 1 counts as +1 and bit 0 as -1. In nonchop mode every emitted `dout` is the two's-complement sum over j of h(j)·x(n-j), where x(n) is the newest accepted sample and h(j) is the number of triples (a,b,c) with each term in 0..R-1 and a+b+c = j. Samples from before the last flush count as 0.
- R3: In nonchop mode the first two decimation boundaries after a flush emit nothing. After that, every R-th accepted sample produces `dout_valid` = 1 for exactly one cycle, in the cycle after that sample's strobe.
- R4: The decimation ratio R equals `sf_word`, except that the values 0 and 1 act as 2.
- R5: In chop mode a result is emitted only on the third decimation boundary after a flush or after the previous result. The two boundaries before it emit nothing.
- R6: `chop_pol` is 0 after reset and after a flush. It stays 0 in nonchop mode. In chop mode it inverts in the same cycle in which `dout_valid` goes to 1.
- R7: In chop mode the emitted value is the sinc-cubed sum of the 3R samples taken since the last polarity change. It is negated when `chop_pol` was 1 during those samples.
- R8: When `sf_word` or `chop_en` differs from the value last applied, all filter state is cleared and settling starts again. A sample strobed in that same cycle is dropped, and no result is emitted in the cycle after it.
- R9: Cycles without `mod_valid` leave the filter state and the decimation count unchanged.
- R10: With R = 4095 and all-ones input, a settled result equals 4095^3 = 68669157375, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_valid | input | 1 | Strobe marking a modulator sample |
| sf_word | input | 12 | Decimation ratio word |
| chop_en | input | 1 | 1 selects chop mode |
| chop_pol | output | 1 | Input polarity control for the front end |
| dout | output | 38 | Signed filtered result |
| dout_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due in the cycle after the strobe of the sample that closes its decimation window: one register stands between that sample and `dout`. The polarity line changes on the same edge. The bench steps a reference model on each rising edge from the inputs that edge consumed, and compares `dout_valid`, `dout` and `chop_pol` one nanosecond later, once the registers have settled. Expected values come from a closed-form count of the sinc-cubed weights over a record of the samples, not from integrators or combs. Configuration changes are tracked in the model on the edge where the block sees them.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int STAGES = 3;

  typedef enum logic [1:0] {
    SETTLE0 = 2'd0,
    SETTLE1 = 2'd1,
    SETTLED = 2'd2
  } settle_e;
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ACC_W  = 38,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clr,
  input  logic signed [ACC_W-1:0] x,
  output logic signed [ACC_W-1:0] sum_nxt
);
  logic signed [ACC_W-1:0] acc_q [STAGES];
  logic signed [ACC_W-1:0] acc_d [STAGES];

  // chained adders: the last stage already includes the current sample
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign acc_d[g] = acc_q[g] + x;
      end else begin : g_chain
        assign acc_d[g] = acc_q[g] + acc_d[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) acc_q[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < STAGES; k++) acc_q[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < STAGES; k++) acc_q[k] <= acc_d[k];
    end
  end

  assign sum_nxt = acc_d[STAGES-1];

  // R9
  integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_q[STAGES-1]));
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ACC_W  = 38,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clr,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] dly_q [STAGES];
  logic signed [ACC_W-1:0] dif   [STAGES];

  always_comb begin
    dif[0] = din - dly_q[0];
    for (int k = 1; k < STAGES; k++) dif[k] = dif[k-1] - dly_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) dly_q[k] <= '0;
    end else if (clr) begin
      for (int k = 0; k < STAGES; k++) dly_q[k] <= '0;
    end else if (en) begin
      dly_q[0] <= din;
      for (int k = 1; k < STAGES; k++) dly_q[k] <= dif[k-1];
    end
  end

  assign dout = dif[STAGES-1];
endmodule

// File: rtl/sinc3_seq.sv
module sinc3_seq
  import sinc3_pkg::*;
#(
  parameter int SF_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mod_valid,
  input  logic [SF_W-1:0] sf_word,
  input  logic            chop_en,
  output logic            flush,
  output logic            smp_en,
  output logic            decim,
  output logic            emit,
  output logic            neg,
  output logic            pol
);
  localparam logic [SF_W-1:0] MIN_R = SF_W'(2);

  logic [SF_W-1:0] sf_q, sf_d, cnt_q, cnt_d, r_last;
  logic            chop_q, chop_d, pol_q, pol_d;
  settle_e         settle_q, settle_d;

  assign flush  = (sf_word != sf_q) || (chop_en != chop_q);
  assign r_last = (sf_q < MIN_R) ? (MIN_R - SF_W'(1)) : (sf_q - SF_W'(1));
  assign smp_en = mod_valid && !flush;
  assign decim  = smp_en && (cnt_q == r_last);
  assign emit   = decim && (settle_q == SETTLED);
  assign neg    = pol_q;
  assign pol    = pol_q;

  always_comb begin
    sf_d     = sf_q;
    chop_d   = chop_q;
    cnt_d    = cnt_q;
    settle_d = settle_q;
    pol_d    = pol_q;
    if (flush) begin
      sf_d     = sf_word;
      chop_d   = chop_en;
      cnt_d    = '0;
      settle_d = SETTLE0;
      pol_d    = 1'b0;
    end else if (smp_en) begin
      cnt_d = decim ? '0 : cnt_q + SF_W'(1);
      if (decim) begin
        case (settle_q)
          SETTLE0: settle_d = SETTLE1;
          SETTLE1: settle_d = SETTLED;
          default: settle_d = chop_q ? SETTLE0 : SETTLED;
        endcase
      end
      if (emit && chop_q) pol_d = ~pol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q     <= '0;
      chop_q   <= 1'b0;
      cnt_q    <= '0;
      settle_q <= SETTLE0;
      pol_q    <= 1'b0;
    end else begin
      sf_q     <= sf_d;
      chop_q   <= chop_d;
      cnt_q    <= cnt_d;
      settle_q <= settle_d;
      pol_q    <= pol_d;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= r_last);
  // R6
  pol_nonchop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_q |-> !pol_q);
  // R6
  pol_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q != $past(pol_q)) |-> ($past(emit) || $past(flush)));
endmodule

// File: rtl/sinc3_chop_decim.sv
module sinc3_chop_decim
  import sinc3_pkg::*;
#(
  parameter int SF_W  = 12,
  localparam int ACC_W = 2 + STAGES * SF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_bit,
  input  logic                    mod_valid,
  input  logic [SF_W-1:0]         sf_word,
  input  logic                    chop_en,
  output logic                    chop_pol,
  output logic signed [ACC_W-1:0] dout,
  output logic                    dout_valid
);
  logic                    flush, smp_en, decim, emit, neg;
  logic signed [ACC_W-1:0] x, integ_out, comb_out, dout_d, dout_q;
  logic                    vld_q;

  // bit 1 -> +1, bit 0 -> -1
  assign x = {{(ACC_W-1){~mod_bit}}, 1'b1};

  sinc3_seq #(.SF_W(SF_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mod_valid(mod_valid), .sf_word(sf_word),
    .chop_en(chop_en), .flush(flush), .smp_en(smp_en), .decim(decim),
    .emit(emit), .neg(neg), .pol(chop_pol)
  );

  sinc3_integ #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(smp_en), .clr(flush),
    .x(x), .sum_nxt(integ_out)
  );

  sinc3_comb #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst_n(rst_n), .en(decim), .clr(flush),
    .din(integ_out), .dout(comb_out)
  );

  always_comb begin
    dout_d = dout_q;
    if (emit) dout_d = neg ? -comb_out : comb_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      vld_q  <= emit;
    end
  end

  assign dout       = dout_q;
  assign dout_valid = vld_q;

  // R3
  valid_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(mod_valid));
  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !dout_valid);
endmodule

// File: tb/sinc3_chop_decim_bench.sv
`timescale 1ns/1ps
module sinc3_chop_decim_bench;
  localparam int SF_W  = 12;
  localparam int ACC_W = 2 + 3 * SF_W;
  localparam int HSZ   = 16384;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    mod_bit, mod_valid, chop_en;
  logic [SF_W-1:0]         sf_word;
  logic                    chop_pol, dout_valid;
  logic signed [ACC_W-1:0] dout;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  sinc3_chop_decim #(.SF_W(SF_W)) u_sinc3_chop_decim (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_valid(mod_valid),
    .sf_word(sf_word), .chop_en(chop_en), .chop_pol(chop_pol),
    .dout(dout), .dout_valid(dout_valid)
  );

  always #2.5 clk = ~clk;

  // reference model state
  int     hist [HSZ];
  int     hlen, m_cnt, m_nb;
  int     sf_a;
  bit     chop_a, m_pol, exp_v;
  longint exp_d, last_dout;

  function automatic longint c2(longint m);
    return (m >= 2) ? m * (m - 1) / 2 : 0;
  endfunction

  function automatic longint wgt(longint j, longint r);
    return c2(j + 2) - 3 * c2(j - r + 2) + 3 * c2(j - 2 * r + 2) - c2(j - 3 * r + 2);
  endfunction

  function automatic longint sinc_sum(int r);
    longint s = 0;
    for (int j = 0; j <= 3 * (r - 1); j++) begin
      if (j < hlen) s += wgt(j, r) * hist[(hlen - 1 - j) % HSZ];
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    int reff;
    #1;
    cyc++;
    if (!rst_n) begin
      sf_a = 0; chop_a = 0; m_cnt = 0; m_nb = 0; m_pol = 0; hlen = 0;
    end else begin
      exp_v = 0;
      if (sf_word != SF_W'(sf_a) || chop_en != chop_a) begin
        sf_a = int'(sf_word); chop_a = chop_en;
        m_cnt = 0; m_nb = 0; m_pol = 0; hlen = 0;
      end else if (mod_valid) begin
        reff = (sf_a < 2) ? 2 : sf_a;
        hist[hlen % HSZ] = mod_bit ? 1 : -1;
        hlen++;
        m_cnt++;
        if (m_cnt == reff) begin
          m_cnt = 0;
          m_nb++;
          if (m_nb >= 3) begin
            exp_v = 1;
            exp_d = sinc_sum(reff);
            if (chop_a) begin
              if (m_pol) exp_d = -exp_d;
              m_pol = ~m_pol;
              m_nb  = 0;
            end
          end
        end
      end
      if (chop_a) chk(dout_valid == exp_v, "R5/R8 result timing (chop)", dout_valid, exp_v);
      else        chk(dout_valid == exp_v, "R3/R4/R8 result timing", dout_valid, exp_v);
      chk(chop_pol == m_pol, "R6 polarity", chop_pol, m_pol);
      if (exp_v && dout_valid) begin
        if (chop_a) chk(longint'(dout) == exp_d, "R7 chop value", longint'(dout), exp_d);
        else        chk(longint'(dout) == exp_d, "R2 sinc3 value", longint'(dout), exp_d);
        last_dout = longint'(dout);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic smp(input bit b, input bit v);
    @(negedge clk);
    mod_bit = b; mod_valid = v;
  endtask

  task automatic cfg(input int sf, input bit ch, input bit v);
    @(negedge clk);
    sf_word = SF_W'(sf); chop_en = ch; mod_valid = v; mod_bit = 1'b1;
  endtask

  task automatic rnd_run(input int n, input int pct);
    for (int i = 0; i < n; i++) smp(1'($urandom), ($urandom % 100) < pct);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; mod_bit = 1'b0; mod_valid = 1'b0; sf_word = '0; chop_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dout_valid == 1'b0, "R1 reset valid", dout_valid, 0);
    chk(dout == '0, "R1 reset dout", longint'(dout), 0);
    chk(chop_pol == 1'b0, "R1 reset polarity", chop_pol, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dout_valid == 1'b0, "R1 idle after reset", dout_valid, 0);

    // R2/R3/R9 nonchop, random bits with gaps in the strobe
    cfg(5, 1'b0, 1'b0);
    rnd_run(400, 70);
    // R4 ratio word 0 behaves as 2
    cfg(0, 1'b0, 1'b0);
    rnd_run(80, 60);
    // R4 ratio word 1 behaves as 2, constant high input
    cfg(1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) smp(1'b1, 1'b1);
    // R5/R6/R7 chop mode, random input
    cfg(7, 1'b1, 1'b0);
    rnd_run(500, 80);
    // R8 change the word while a sample is strobed, mid-period
    cfg(6, 1'b1, 1'b1);
    rnd_run(300, 90);
    // R8 leave chop mode mid-run
    cfg(6, 1'b0, 1'b1);
    rnd_run(200, 90);
    // R7 chop pairs with constant input: results alternate in sign
    cfg(2, 1'b1, 1'b0);
    for (int i = 0; i < 60; i++) smp(1'b1, 1'b1);
    // R10 largest ratio, full-scale input
    cfg(4095, 1'b0, 1'b0);
    for (int i = 0; i < 3 * 4095 + 10; i++) smp(1'b1, 1'b1);
    smp(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(last_dout == 64'sd68669157375, "R10 full-scale result", last_dout, 64'sd68669157375);
    // R9 idle strobe: no result while mod_valid is low
    for (int i = 0; i < 20; i++) smp(1'b1, 1'b0);
    chk(dout_valid == 1'b0, "R9 no result while idle", dout_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule